// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects eight hardware event lines into sticky pending bits and raises a single interrupt request toward the processor. A one-cycle pulse on an event input sets that source's pending bit, and the bit stays set until software clears it. A mask register selects which pending bits may drive the request line. Software clears pending bits by writing ones to a clear register. Writing a zero to a bit of that register leaves the bit alone.

When the processor acknowledges the interrupt, the block computes the vector number. The vector is a programmable base plus the index of the highest-numbered source that is both enabled and pending. The result is captured into a holding register and presented on a valid/ready output. The captured vector stays stable until the consumer takes it with ready. While a vector is held, further acknowledge requests are ignored, so back-pressure simply holds the current vector. Nesting and the processor's fetch of the vector are outside this block.

Top module: `irqvec_ctrl`

## Requirements
- R1: After reset the base, mask and pending registers read zero, `irq_o` is 0 and `vec_valid_o` is 0.
- R2: A 1 on `evt_i[i]` at a clock edge sets pending bit i. The bit stays set until it is cleared through the clear register. The source indices are: 7 horizontal-blank timer, 6 vertical-blank start, 5 vertical-blank timer, 4 line-compare match, 3 serial receive, 2 alarm, 1 key press, 0 serial transmit.
- R3: A write to register select 3 (clear) clears every pending bit written as 1 and leaves the other bits unchanged. For example, writing 0x40 clears only bit 6.
- R4: If an event pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: `irq_o` is registered. After each edge it equals the OR of (pending AND mask) as they stood before that edge.
- R6: A pending bit whose mask bit is 0 does not raise `irq_o`, but it remains visible in the pending readback.
- R7: The vector equals base + index of the highest enabled pending bit, taken modulo 256. A base of 0x20 with bit 6 gives 0x26.
- R8: When `inta_i` is 1, no vector is held and an enabled bit is pending, `vec_valid_o` rises after the edge. While `vec_valid_o`=1 and `vec_ready_i`=0, the valid and `vec_o` hold stable and `inta_i` has no effect. An edge with both valid and ready high drops the valid.
- R9: `inta_i` with no enabled pending bit does not assert `vec_valid_o`.
- R10: The register selects are:
  - 0: base, read/write.
  - 1: mask, read/write.
  - 2: pending, read-only; a write to it is ignored.
  - 3: clear, write-only; it reads 0.
  `reg_rdata_o` is a combinational read of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel_i | input | 2 | Register select (0 base, 1 mask, 2 pending, 3 clear) |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of selected register |
| evt_i | input | 8 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt request to processor |
| inta_i | input | 1 | Interrupt acknowledge from processor |
| vec_valid_o | output | 1 | Vector available |
| vec_ready_i | input | 1 | Consumer takes the vector |
| vec_o | output | 8 | Vector number |

## Verification
The assertions check the following on every cycle:
- Events set their pending bits.
- Pending bits fall only when a clear register write occurs.
- `irq_o` tracks the previous cycle's enabled pending set.
- A held vector stays stable under back-pressure.
- A vector never appears without an acknowledge while something was enabled and pending.

Some behaviours can only be shown by the bench's scenarios:
- The choice of the highest-index source.
- Base arithmetic wrapping past 0xFF.
- Register readback and the ignored write to the pending register.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqvec_regs.sv
module irqvec_regs #(
  parameter int DW   = 8,
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   base_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] clr_o
);
  import irqvec_pkg::*;
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      mask_o <= '0;
    end else if (wr_i) begin
      if (sel == SEL_BASE) base_o <= wdata_i;
      if (sel == SEL_MASK) mask_o <= wdata_i[NSRC-1:0];
    end
  end

  // clear strobe vector, only on a write to the clear register
  assign clr_o = (wr_i && sel == SEL_CLEAR) ? wdata_i[NSRC-1:0] : '0;
endmodule

// File: rtl/irqvec_pend.sv
module irqvec_pend #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  // one sticky cell per source; set wins over clear
  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)         pend_o[g] <= 1'b0;
      else if (evt_i[g])  pend_o[g] <= 1'b1;
      else if (clr_i[g])  pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqvec_prio.sv
module irqvec_prio #(
  parameter int NSRC = 8,
  parameter int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && !any_o) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqvec_port.sv
module irqvec_port #(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inta_i,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] base_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] vec_next;
  assign vec_next = base_i + {{(DW-IW){1'b0}}, idx_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (valid_o) begin
      if (ready_i) valid_o <= 1'b0;
    end else if (inta_i && any_i) begin
      valid_o <= 1'b1;
      data_o  <= vec_next;
    end
  end
endmodule

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl #(
  parameter int NSRC = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_sel_i,
  input  logic            reg_wr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic [NSRC-1:0] evt_i,
  output logic            irq_o,
  input  logic            inta_i,
  output logic            vec_valid_o,
  input  logic            vec_ready_i,
  output logic [DW-1:0]   vec_o
);
  import irqvec_pkg::*;
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [DW-1:0]   base_q;
  logic [NSRC-1:0] mask_q, clr_s, pend_q, live_s;
  logic            any_s;
  logic [IW-1:0]   idx_s;

  irqvec_regs #(.DW(DW), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(reg_sel_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .base_o(base_q), .mask_o(mask_q), .clr_o(clr_s));

  irqvec_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_s), .pend_o(pend_q));

  assign live_s = pend_q & mask_q;

  irqvec_prio #(.NSRC(NSRC), .IW(IW)) u_prio (
    .req_i(live_s), .any_o(any_s), .idx_o(idx_s));

  irqvec_port #(.DW(DW), .IW(IW)) u_port (
    .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .any_i(any_s), .idx_i(idx_s),
    .base_i(base_q), .valid_o(vec_valid_o), .ready_i(vec_ready_i), .data_o(vec_o));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_s;
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel_i))
      SEL_BASE:  reg_rdata_o = base_q;
      SEL_MASK:  reg_rdata_o = DW'(mask_q);
      SEL_PEND:  reg_rdata_o = DW'(pend_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqvec_ctrl_chk.sv
module irqvec_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      reg_sel_i,
  input logic            reg_wr_i,
  input logic [NSRC-1:0] evt_i,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic            irq_o,
  input logic            inta_i,
  input logic            vec_valid_o,
  input logic            vec_ready_i,
  input logic [DW-1:0]   vec_o
);
  logic clr_wr;
  assign clr_wr = reg_wr_i && (reg_sel_i == 2'd3);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(pend_q) & ~pend_q) == '0)); // R2

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(pend_q) & $past(mask_q)))); // R5

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_o))); // R8

  AST_VEC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid_o) |-> $past(inta_i && ((pend_q & mask_q) != '0))); // R9
endmodule

bind irqvec_ctrl irqvec_ctrl_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
  .evt_i(evt_i), .pend_q(pend_q), .mask_q(mask_q), .irq_o(irq_o),
  .inta_i(inta_i), .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i),
  .vec_o(vec_o));

// File: tb/irqvec_ctrl_bench.sv
module irqvec_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [7:0] evt_i = '0;
  logic       irq_o;
  logic       inta_i = 1'b0;
  logic       vec_valid_o;
  logic       vec_ready_i = 1'b0;
  logic [7:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] base_m, mask_m, pend_m, vd_m;
  logic       irq_m, vv_m;

  irqvec_ctrl u_irqvec_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .evt_i(evt_i),
    .irq_o(irq_o), .inta_i(inta_i), .vec_valid_o(vec_valid_o),
    .vec_ready_i(vec_ready_i), .vec_o(vec_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] top_vec(input logic [7:0] b, input logic [7:0] live);
    logic [7:0] v = b;
    for (int i = 0; i < 8; i++) if (live[i]) v = b + 8'(i);
    return v;
  endfunction

  function automatic logic [7:0] read_exp(input logic [1:0] s);
    case (s)
      2'd0: return base_m;
      2'd1: return mask_m;
      2'd2: return pend_m;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance model at the edge, settle
  task automatic cyc(input logic [7:0] evt, input logic wr, input logic [1:0] sel,
                     input logic [7:0] wd, input logic inta, input logic rdy);
    logic [7:0] live;
    @(negedge clk);
    evt_i = evt; reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
    inta_i = inta; vec_ready_i = rdy;
    @(posedge clk);
    live = pend_m & mask_m;
    irq_m = |live;
    if (vv_m) begin
      if (rdy) vv_m = 1'b0;
    end else if (inta && live != 0) begin
      vv_m = 1'b1;
      vd_m = top_vec(base_m, live);
    end
    pend_m = (pend_m & ~((wr && sel == 2'd3) ? wd : 8'h00)) | evt;
    if (wr && sel == 2'd0) base_m = wd;
    if (wr && sel == 2'd1) mask_m = wd;
    #1;
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, irq_m});
    chk({tag, " vvalid"}, {7'd0, vec_valid_o}, {7'd0, vv_m});
    if (vv_m) chk({tag, " vec"}, vec_o, vd_m);
  endtask

  task automatic idle(); cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b0, 1'b0); endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    base_m = 0; mask_m = 0; pend_m = 0; vd_m = 0; irq_m = 0; vv_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_sel_i = 2'(s); #1;
      chk("R1 readback", reg_rdata_o, 8'h00);
    end
    chk_outs("R1");

    // R10 register access: base and mask read back, write to pending ignored
    cyc(8'h00, 1'b1, 2'd0, 8'h20, 1'b0, 1'b0);
    chk("R10 base", reg_rdata_o, 8'h20);
    cyc(8'h00, 1'b1, 2'd1, 8'h40, 1'b0, 1'b0);
    chk("R10 mask", reg_rdata_o, 8'h40);
    cyc(8'h00, 1'b1, 2'd2, 8'hFF, 1'b0, 1'b0);
    chk("R10 pend write ignored", reg_rdata_o, 8'h00);
    chk_outs("R10");

    // R2 vertical-blank start (bit 6) latched, R5 irq one edge later
    cyc(8'h40, 1'b0, 2'd2, 8'h00, 1'b0, 1'b0);
    chk("R2 pend set", reg_rdata_o, 8'h40);
    chk("R5 irq not yet", {7'd0, irq_o}, 8'h00);
    idle();
    chk("R2 pend held", reg_rdata_o, 8'h40);
    chk("R5 irq up", {7'd0, irq_o}, 8'h01);
    // R7/R8 vector 0x26, held under back-pressure
    cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
    chk("R7 vec base+6", vec_o, 8'h26);
    chk("R8 valid", {7'd0, vec_valid_o}, 8'h01);
    cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
    chk_outs("R8 hold");
    cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b0, 1'b1);
    chk("R8 taken", {7'd0, vec_valid_o}, 8'h00);
    // R3 clear 0x40 while bit 1 pending too
    cyc(8'h02, 1'b0, 2'd2, 8'h00, 1'b0, 1'b0);
    cyc(8'h00, 1'b1, 2'd3, 8'h40, 1'b0, 1'b0);
    chk("R3 clear only bit6", reg_rdata_o, 8'h00);
    reg_sel_i = 2'd2; #1;
    chk("R3 bit1 stays", reg_rdata_o, 8'h02);
    // R6 bit1 masked: no irq
    idle(); idle();
    chk("R6 masked no irq", {7'd0, irq_o}, 8'h00);
    // R9 inta with nothing enabled
    cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
    idle();
    chk("R9 no vector", {7'd0, vec_valid_o}, 8'h00);
    // R4 event and clear on same bit
    cyc(8'h02, 1'b1, 2'd3, 8'h02, 1'b0, 1'b0);
    reg_sel_i = 2'd2; #1;
    chk("R4 set wins", reg_rdata_o, 8'h02);
    // R7 priority and wrap: base 0xFE, bits 7 and 1 enabled
    cyc(8'h80, 1'b1, 2'd0, 8'hFE, 1'b0, 1'b0);
    cyc(8'h00, 1'b1, 2'd1, 8'hFF, 1'b0, 1'b0);
    cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
    chk("R7 highest+wrap", vec_o, 8'h05);
    cyc(8'h00, 1'b0, 2'd2, 8'h00, 1'b0, 1'b1);
    chk_outs("R7");

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] ev;
      logic       w;
      logic [1:0] s;
      ev = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      w  = (($urandom % 3) == 0);
      s  = 2'($urandom);
      if (s == 2'd0 && ($urandom % 4) != 0) w = 1'b0;
      cyc(ev, w, s, 8'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0);
      chk_outs("R5/R8 random");
      chk("R10 random read", reg_rdata_o, read_exp(s));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule